// File: doc/BRIEF.md
# Memory-Mapped Multi-Queue Result FIFO Bank

This block is a set of independent hardware FIFOs behind one small memory-mapped window. A producer thread hands a result word to its checker thread with a single bus store. The store data is the result. The store address names the target queue. Software does no pointer arithmetic, marks nothing valid and takes no lock. Each producer/checker pairing owns one queue. The checker pops words in arrival order with loads from the same queue's data address and compares them against values it has recomputed itself.

Each queue occupies a 16-byte slot, and address bits [5:4] select the slot. Offset 0x0 in a slot is the data port: a write pushes and a read pops. Offset 0x8 is a status word that reports empty, full, the entry count and two sticky error flags. The write side and the read side are separate channels, so the same cycle can carry one enqueue and one dequeue. Read data is registered.

Top module: `mmq_bank`

## Requirements
- R1: A write to offset 0x0 of queue q (address bits [5:4] = q) stores `wr_data` in that queue and raises its count by one, provided the queue is not full.
- R2: A read from offset 0x0 of a non-empty queue returns that queue's oldest word on `rd_data` in the cycle after `rd_en`, and removes the word. Words come out in the order they were written.
- R3: Traffic to one queue leaves the contents and the status of every other queue unchanged.
- R4: A read from offset 0x8 returns the status word as it stood before that clock edge. Bit 0 is empty, bit 1 is full, bit 2 is the overflow flag, bit 3 is the underflow flag, bits [12:8] hold the entry count, and every other bit reads 0.
- R5: A write to the data port of a full queue is dropped, leaving contents and count unchanged, and sets the queue's overflow flag.
- R6: A write to offset 0x8 clears the overflow flag when data bit 2 is 1 and the underflow flag when data bit 3 is 1. A 0 in either bit leaves that flag unchanged.
- R7: A read from the data port of an empty queue returns zero, leaves the count at zero and sets the queue's underflow flag.
- R8: An enqueue and a dequeue on the same full queue in the same cycle both succeed. The oldest word is returned, the new word is stored, the count stays at 16 and no overflow is flagged.
- R9: An enqueue and a dequeue on the same empty queue in the same cycle return zero and set underflow, and the written word is stored, so the count becomes 1.
- R10: After reset every queue is empty with both flags clear, and `rd_data` is zero.
- R11: Writes to offsets other than 0x0 and 0x8 have no effect. Reads from those offsets return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for one bus write this cycle |
| wr_addr | input | 6 | Write address: [5:4] queue, [3:0] offset |
| wr_data | input | 32 | Word to enqueue, or flag-clear mask for a status write |
| rd_en | input | 1 | Read strobe for one bus read this cycle |
| rd_addr | input | 6 | Read address: [5:4] queue, [3:0] offset |
| rd_data | output | 32 | Registered read result, valid in the cycle after `rd_en` |

## Verification
The bench builds the block with its default values: four queues, sixteen entries and 32-bit words. With a depth of sixteen, a queue fills after sixteen writes, so the dropped seventeenth write and the full-queue enqueue-plus-dequeue case are both reached quickly. With four queues, all select codes are used, and the bench can drive traffic to one queue while watching that the others stay untouched. A 5-bit count at bits [12:8] lets a full queue report a count of exactly 16.

// File: rtl/qbank_pkg.sv
package qbank_pkg;
   // Byte offsets inside one queue slot.
   localparam int SLOT_OFF_DATA = 'h0;
   localparam int SLOT_OFF_STAT = 'h8;
   // Status word bit positions.
   localparam int ST_EMPTY_BIT = 0;
   localparam int ST_FULL_BIT  = 1;
   localparam int ST_OVF_BIT   = 2;
   localparam int ST_UNF_BIT   = 3;
   localparam int ST_CNT_LSB   = 8;

   typedef enum logic [1:0] {
      KIND_DATA = 2'd0,
      KIND_STAT = 2'd1,
      KIND_NONE = 2'd2
   } reg_kind_e;
endpackage

// File: rtl/qbank_decode.sv
module qbank_decode
   import qbank_pkg::*;
#(
   parameter int NUM_Q   = 4,
   parameter int SEL_LSB = 4,
   localparam int SEL_W  = $clog2(NUM_Q),
   localparam int ADDR_W = SEL_LSB + SEL_W
) (
   input  logic              en,
   input  logic [ADDR_W-1:0] addr,
   output logic [NUM_Q-1:0]  hit,
   output reg_kind_e         kind
);
   logic [SEL_LSB-1:0] offset;
   logic [SEL_W-1:0]   sel;

   assign offset = addr[SEL_LSB-1:0];
   assign sel    = addr[SEL_LSB +: SEL_W];

   always_comb begin
      if (offset == SEL_LSB'(SLOT_OFF_DATA))      kind = KIND_DATA;
      else if (offset == SEL_LSB'(SLOT_OFF_STAT)) kind = KIND_STAT;
      else                                        kind = KIND_NONE;
   end

   for (genvar i = 0; i < NUM_Q; i++) begin : g_hit
      assign hit[i] = en && (sel == SEL_W'(i));
   end

   initial begin
      assert (SEL_LSB > $clog2(SLOT_OFF_STAT))
         else $error("slot too narrow for the status offset");
   end
endmodule

// File: rtl/qbank_fifo.sv
module qbank_fifo #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 16,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   input  logic              clr_ovf,
   input  logic              clr_unf,
   output logic [DATA_W-1:0] head_data,
   output logic [CNT_W-1:0]  count,
   output logic              empty,
   output logic              full,
   output logic              ovf,
   output logic              unf
);
   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic              do_push, do_pop, set_ovf, set_unf;

   assign empty     = (count == '0);
   assign full      = (count == CNT_W'(DEPTH));
   assign do_pop    = pop && !empty;
   assign do_push   = push && (!full || do_pop);
   assign set_ovf   = push && !do_push;
   assign set_unf   = pop && empty;
   assign head_data = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
         ovf    <= 1'b0;
         unf    <= 1'b0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + PTR_W'(1);
         if (do_pop)  rd_ptr <= rd_ptr + PTR_W'(1);
         unique case ({do_push, do_pop})
            2'b10:   count <= count + CNT_W'(1);
            2'b01:   count <= count - CNT_W'(1);
            default: count <= count;
         endcase
         if (set_ovf)      ovf <= 1'b1;
         else if (clr_ovf) ovf <= 1'b0;
         if (set_unf)      unf <= 1'b1;
         else if (clr_unf) unf <= 1'b0;
      end
   end

   initial begin
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("DEPTH must be a power of two, at least 2");
   end

   // R1
   push_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push && !full && !pop |=> count == $past(count) + CNT_W'(1));
   // R3
   idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !push && !pop |=> $stable(count) && $stable(head_data));
   // R5
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push && full && !pop |=> ovf && $stable(count));
   // R6
   ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_ovf && !(push && full && !pop) |=> !ovf);
   // R7
   underflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop && empty && !push |=> unf && count == '0);
   // R8
   pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push && pop && !empty |=> count == $past(count) && !$rose(ovf));
endmodule

// File: rtl/mmq_bank.sv
module mmq_bank
   import qbank_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int DEPTH   = 16,
   parameter int NUM_Q   = 4,
   parameter int SEL_LSB = 4,
   localparam int SEL_W  = $clog2(NUM_Q),
   localparam int ADDR_W = SEL_LSB + SEL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int CNT_W = $clog2(DEPTH + 1);

   logic [NUM_Q-1:0]             w_hit, r_hit;
   reg_kind_e                    w_kind, r_kind;
   logic [SEL_W-1:0]             r_sel;
   logic [NUM_Q-1:0][DATA_W-1:0] head_w, stat_w;
   logic [NUM_Q-1:0]             empty_w;

   function automatic logic [DATA_W-1:0] pack_stat(
      input logic [CNT_W-1:0] cnt, input logic e, input logic f,
      input logic o, input logic u);
      logic [DATA_W-1:0] w;
      w = '0;
      w[ST_EMPTY_BIT] = e;
      w[ST_FULL_BIT]  = f;
      w[ST_OVF_BIT]   = o;
      w[ST_UNF_BIT]   = u;
      w[ST_CNT_LSB +: CNT_W] = cnt;
      return w;
   endfunction

   qbank_decode #(.NUM_Q(NUM_Q), .SEL_LSB(SEL_LSB)) wdec_i (
      .en(wr_en), .addr(wr_addr), .hit(w_hit), .kind(w_kind));
   qbank_decode #(.NUM_Q(NUM_Q), .SEL_LSB(SEL_LSB)) rdec_i (
      .en(rd_en), .addr(rd_addr), .hit(r_hit), .kind(r_kind));

   assign r_sel = rd_addr[SEL_LSB +: SEL_W];

   for (genvar i = 0; i < NUM_Q; i++) begin : g_q
      logic [CNT_W-1:0] cnt;
      logic             full, ovf, unf;
      qbank_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) fifo_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .push     (w_hit[i] && w_kind == KIND_DATA),
         .push_data(wr_data),
         .pop      (r_hit[i] && r_kind == KIND_DATA),
         .clr_ovf  (w_hit[i] && w_kind == KIND_STAT && wr_data[ST_OVF_BIT]),
         .clr_unf  (w_hit[i] && w_kind == KIND_STAT && wr_data[ST_UNF_BIT]),
         .head_data(head_w[i]),
         .count    (cnt),
         .empty    (empty_w[i]),
         .full     (full),
         .ovf      (ovf),
         .unf      (unf)
      );
      assign stat_w[i] = pack_stat(cnt, empty_w[i], full, ovf, unf);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
      end else if (rd_en) begin
         unique case (r_kind)
            KIND_DATA: rd_data <= empty_w[r_sel] ? '0 : head_w[r_sel];
            KIND_STAT: rd_data <= stat_w[r_sel];
            default:   rd_data <= '0;
         endcase
      end
   end

   initial begin
      assert (NUM_Q >= 2 && (NUM_Q & (NUM_Q - 1)) == 0)
         else $error("NUM_Q must be a power of two, at least 2");
      assert (ST_CNT_LSB + CNT_W <= DATA_W)
         else $error("DATA_W too narrow for the status word");
   end

   // R7
   empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && r_kind == KIND_DATA && empty_w[r_sel] |=> rd_data == '0);
   // R11
   hole_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && r_kind == KIND_NONE |=> rd_data == '0);
   // R2
   pop_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && r_kind == KIND_DATA && !empty_w[r_sel] |=> rd_data == $past(head_w[r_sel]));
endmodule

// File: tb/mmq_bank_tb_top.sv
`timescale 1ns/1ps
module mmq_bank_tb_top;
   localparam int NQ  = 4;
   localparam int DEP = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [5:0]  wr_addr = '0, rd_addr = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;

   int total = 0;
   int bad = 0;

   logic [31:0] mq [NQ][$];
   bit          movf [NQ];
   bit          munf [NQ];
   logic [31:0] exp_val [$];
   string       exp_tag [$];

   always #2.5 clk = ~clk;

   mmq_bank dut_i (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data));

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mstat(input int q);
      int n = mq[q].size();
      return 32'((n << 8) | (int'(munf[q]) << 3) | (int'(movf[q]) << 2) |
                 (int'(n == DEP) << 1) | int'(n == 0));
   endfunction

   // One bus cycle; driven at a falling edge, model updated in bus order.
   task automatic bus(input bit we, input int wq, input logic [3:0] woff,
                      input logic [31:0] wd, input bit re, input int rq,
                      input logic [3:0] roff, input string tag);
      int  wpre = mq[wq].size();
      bit  popped = 0;
      bit  set_unf = 0;
      logic [31:0] e = '0;
      wr_en = we; wr_addr = {wq[1:0], woff}; wr_data = wd;
      rd_en = re; rd_addr = {rq[1:0], roff};
      if (re) begin
         if (roff == 4'h8) e = mstat(rq);
         else if (roff == 4'h0) begin
            if (mq[rq].size() == 0) set_unf = 1;
            else begin e = mq[rq].pop_front(); popped = (rq == wq); end
         end
         exp_val.push_back(e);
         exp_tag.push_back(tag);
      end
      if (we && woff == 4'h8) begin
         if (wd[2]) movf[wq] = 0;
         if (wd[3]) munf[wq] = 0;
      end
      if (set_unf) munf[rq] = 1;
      if (we && woff == 4'h0) begin
         if (wpre == DEP && !popped) movf[wq] = 1;
         else mq[wq].push_back(wd);
      end
      @(negedge clk);
      wr_en = 0; rd_en = 0;
   endtask

   task automatic wr(input int q, input logic [3:0] off, input logic [31:0] d, input string tag);
      bus(1, q, off, d, 0, 0, 4'h0, tag);
   endtask

   task automatic rd(input int q, input logic [3:0] off, input string tag);
      bus(0, 0, 4'h0, 32'h0, 1, q, off, tag);
   endtask

   // Monitor: compares each registered read result with the scoreboard.
   initial begin
      forever begin
         bit fire;
         @(posedge clk);
         fire = rd_en;
         #1;
         if (fire) begin
            if (exp_val.size() == 0) check("scoreboard-empty", rd_data, 32'hx);
            else check(exp_tag.pop_front(), rd_data, exp_val.pop_front());
         end
      end
   end

   initial begin
      #(100000 * 5);
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 rd_data after reset", rd_data, 32'h0);
      for (int q = 0; q < NQ; q++) rd(q, 4'h8, "R10 status after reset");

      // R1 R2 R3: two queues loaded, order and isolation
      for (int i = 0; i < 3; i++) wr(0, 4'h0, 32'hA000_0000 + i, "R1 push q0");
      for (int i = 0; i < 2; i++) wr(2, 4'h0, 32'hC000_0000 + i, "R1 push q2");
      rd(0, 4'h8, "R4 status q0 count 3");
      rd(1, 4'h8, "R3 q1 untouched");
      for (int i = 0; i < 3; i++) rd(0, 4'h0, "R2 pop q0 order");
      rd(2, 4'h8, "R3 q2 unaffected by q0 pops");
      // interleaved: push q3 while popping q2
      bus(1, 3, 4'h0, 32'hD000_0001, 1, 2, 4'h0, "R3 pop q2 during q3 push");
      rd(2, 4'h0, "R2 pop q2 last");
      rd(3, 4'h0, "R2 pop q3");

      // R5 R6: fill q1, overflow, clear
      for (int i = 0; i < DEP; i++) wr(1, 4'h0, 32'hB000_0000 + i, "R1 fill q1");
      rd(1, 4'h8, "R4 status q1 full");
      wr(1, 4'h0, 32'hDEAD_BEEF, "R5 write to full");
      rd(1, 4'h8, "R5 overflow set, count 16");
      wr(1, 4'h8, 32'h0000_0008, "R6 clear other bit only");
      rd(1, 4'h8, "R6 overflow kept when bit2 is 0");
      wr(1, 4'h8, 32'h0000_0004, "R6 clear overflow");
      rd(1, 4'h8, "R6 overflow cleared");

      // R8: simultaneous on full queue
      bus(1, 1, 4'h0, 32'hB000_0100, 1, 1, 4'h0, "R8 pop oldest while pushing into full");
      rd(1, 4'h8, "R8 count 16, no overflow");
      for (int i = 0; i < DEP; i++) rd(1, 4'h0, "R2 drain q1 order");
      rd(1, 4'h8, "R2 q1 empty after drain");

      // R7: read empty
      rd(3, 4'h0, "R7 empty read returns zero");
      rd(3, 4'h8, "R7 underflow set, count 0");
      wr(3, 4'h8, 32'h0000_0008, "R6 clear underflow");
      rd(3, 4'h8, "R6 underflow cleared");

      // R9: simultaneous on empty queue
      bus(1, 3, 4'h0, 32'h1234_5678, 1, 3, 4'h0, "R9 pop empty while pushing");
      rd(3, 4'h8, "R9 count 1, underflow set");
      rd(3, 4'h0, "R9 stored word");

      // R11: unmapped offsets
      wr(0, 4'h4, 32'h5555_AAAA, "R11 write hole");
      wr(2, 4'hC, 32'h5555_AAAA, "R11 write hole");
      rd(0, 4'h8, "R11 q0 still empty");
      rd(2, 4'h8, "R11 q2 still empty");
      wr(0, 4'h0, 32'h7777_0000, "R1 push q0");
      rd(0, 4'h4, "R11 hole read returns zero");
      rd(0, 4'h8, "R11 hole read popped nothing");
      rd(0, 4'h0, "R2 pop q0");

      repeat (2) @(negedge clk);
      check("R2 scoreboard drained", 32'(exp_val.size()), 32'h0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule